// File: doc/BRIEF.md
# Column-Interleaved Pixel Pair Buffer

This block is the on-chip pixel store for a deblocking stage. It keeps a macroblock's 4x4 blocks together with the neighbouring blocks they share edges with. Each memory word holds one 4-pixel row of one 4x4 block. The blocks are grouped into numbered block columns of `SLOTS` blocks each. Even-numbered columns live in one bank and odd-numbered columns in the other. Because two neighbouring columns never share a bank, the eight pixels on either side of a vertical block edge come out of a single access: one row from each bank.

There are two request ports. The first is a write port. It either stores one 32-bit word from the system bus or writes back a filtered 8-pixel span into two neighbouring columns. The second is a read port. It returns either one word or an 8-pixel span that straddles a column edge. Inside each bank, a word's address is the block's base plus the row number. A read and a write may proceed in the same cycle when they touch different banks. An overlap on a bank is reported as a clash, and so is a request that points outside the stored area.

Top module: `pair_pixel_buffer`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `rd_valid_o`, `clash_o` and `range_o` are 0 and `rd_data_o` is all zeros.
- R2: An accepted single read (`rd_pair_i`=0) of column c, slot s and row r raises `rd_valid_o` for one cycle, in the cycle after the request. `rd_data_o[31:0]` then holds the stored word and `rd_data_o[63:32]` is zero. Pixel 0, the leftmost, sits in bits [7:0].
- R3: An accepted pair read (`rd_pair_i`=1) at column c returns column c's word in `rd_data_o[31:0]` and column c+1's word in `rd_data_o[63:32]`, for the same slot and row, for both even and odd c.
- R4: A pair write at column c stores `wr_data_i[31:0]` into column c and `wr_data_i[63:32]` into column c+1, at the same slot and row. A single write stores `wr_data_i[31:0]` into column c only.
- R5: Even columns use one bank and odd columns use the other. A read and a write issued together to columns of different parity both take effect, and no clash is reported.
- R6: When a read and a write issued together need the same bank (a pair access needs both banks), `clash_o` pulses in the next cycle. The read is dropped, so `rd_valid_o` stays 0. The write still takes effect.
- R7: A request whose column is not below `NUM_COLS`, or a pair request at the last column, is dropped and `range_o` pulses in the next cycle. A dropped write leaves memory unchanged. A dropped request never causes a clash, and a valid request on the other port still proceeds.
- R8: Every (column, slot, row) triple below the configured limits maps to its own word. Filling every word with a distinct value and reading all of them back returns each value unchanged.
- R9: `rd_data_o` keeps its value in every cycle in which `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Read request |
| rd_pair_i | input | 1 | 1: 8-pixel span across columns c and c+1; 0: one word |
| rd_col_i | input | 4 | Block column of the read (left column for a pair) |
| rd_slot_i | input | 2 | Block position within the column |
| rd_row_i | input | 2 | Pixel row within the block |
| wr_en_i | input | 1 | Write request (bus load or filtered write-back) |
| wr_pair_i | input | 1 | 1: write both halves into columns c and c+1; 0: one word |
| wr_col_i | input | 4 | Block column of the write |
| wr_slot_i | input | 2 | Block position within the column |
| wr_row_i | input | 2 | Pixel row within the block |
| wr_data_i | input | 64 | Write data; low half for column c, high half for c+1 |
| rd_valid_o | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data_o | output | 64 | Read data; low half column c, high half column c+1 or zero |
| clash_o | output | 1 | Previous cycle's read and write needed the same bank |
| range_o | output | 1 | Previous cycle held a request outside the stored area |

## Verification
The assertions assume that no request is raised while reset is held. Every check of a result therefore starts from a bench that keeps both enables low until reset has been released. The properties also take the read controls as steady for the whole cycle in which the enable is high. The bench drives every request at the falling edge, holds it for exactly one rising edge and then returns both ports to idle. Because of this, a result is never mixed with a leftover request from an earlier scenario.

// File: rtl/pbuf_pkg.sv
`timescale 1ns/1ps
package pbuf_pkg;

  // Kind of access a port asks for.
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_SPAN = 2'd2
  } acc_kind_t;

  // Word index inside a bank: block base (column pair index and slot) plus row.
  function automatic int word_index(int col, int slot, int row, int slots, int rows);
    return (((col / 2) * slots) + slot) * rows + row;
  endfunction

  // Number of words a bank needs for the columns of the given parity.
  function automatic int bank_depth(int num_cols, int parity, int slots, int rows);
    int ncols;
    ncols = (parity == 0) ? (num_cols + 1) / 2 : num_cols / 2;
    if (ncols < 1) ncols = 1;
    return ncols * slots * rows;
  endfunction

endpackage

// File: rtl/pb_addr_gen.sv
`timescale 1ns/1ps
module pb_addr_gen
  import pbuf_pkg::*;
#(
  parameter int NUM_COLS = 11,
  parameter int SLOTS    = 4,
  parameter int ROWS     = 4,
  parameter int COL_W    = 4,
  parameter int SLOT_W   = 2,
  parameter int ROW_W    = 2,
  parameter int AW       = 7
) (
  input  logic                 en_i,
  input  logic                 pair_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [ROW_W-1:0]     row_i,
  output logic                 ok_o,
  output logic                 bad_o,
  output acc_kind_t            kind_o,
  output logic [1:0]           hit_o,
  output logic [1:0]           hi_sel_o,
  output logic [1:0][AW-1:0]   addr_o
);

  logic in_range;

  always_comb begin
    in_range = (int'(col_i) < NUM_COLS) &&
               (int'(slot_i) < SLOTS) &&
               (int'(row_i) < ROWS) &&
               (!pair_i || (int'(col_i) < NUM_COLS - 1));
  end

  assign ok_o   = en_i && in_range;
  assign bad_o  = en_i && !in_range;
  assign kind_o = !ok_o ? ACC_IDLE : (pair_i ? ACC_SPAN : ACC_WORD);

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      logic             own;
      logic [COL_W:0]   bcol;
      assign own         = (col_i[0] == (b == 1));
      assign bcol        = own ? {1'b0, col_i} : ({1'b0, col_i} + 1'b1);
      assign hit_o[b]    = (kind_o == ACC_SPAN) || ((kind_o == ACC_WORD) && own);
      assign hi_sel_o[b] = !own;
      assign addr_o[b]   = AW'(word_index(int'(bcol), int'(slot_i), int'(row_i), SLOTS, ROWS));
    end
  endgenerate

endmodule

// File: rtl/pb_bank.sv
`timescale 1ns/1ps
module pb_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 96,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (re_i) rdata_o <= mem[addr_i];
  end

endmodule

// File: rtl/pb_lane_mux.sv
`timescale 1ns/1ps
module pb_lane_mux #(
  parameter int W = 32
) (
  input  logic [1:0][W-1:0] bank_i,
  input  logic              par_i,
  input  logic              pair_i,
  output logic [2*W-1:0]    data_o
);

  logic [W-1:0] lo, hi;

  always_comb begin
    lo     = par_i ? bank_i[1] : bank_i[0];
    hi     = par_i ? bank_i[0] : bank_i[1];
    data_o = pair_i ? {hi, lo} : {{W{1'b0}}, lo};
  end

endmodule

// File: rtl/pair_pixel_buffer.sv
`timescale 1ns/1ps
module pair_pixel_buffer
  import pbuf_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int PIX_PER_ROW = 4,
  parameter int ROWS        = 4,
  parameter int SLOTS       = 4,
  parameter int NUM_COLS    = 11,
  localparam int WORD_W     = PIX_W * PIX_PER_ROW,
  localparam int COL_W      = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en_i,
  input  logic                  rd_pair_i,
  input  logic [COL_W-1:0]      rd_col_i,
  input  logic [SLOT_W-1:0]     rd_slot_i,
  input  logic [ROW_W-1:0]      rd_row_i,
  input  logic                  wr_en_i,
  input  logic                  wr_pair_i,
  input  logic [COL_W-1:0]      wr_col_i,
  input  logic [SLOT_W-1:0]     wr_slot_i,
  input  logic [ROW_W-1:0]      wr_row_i,
  input  logic [2*WORD_W-1:0]   wr_data_i,
  output logic                  rd_valid_o,
  output logic [2*WORD_W-1:0]   rd_data_o,
  output logic                  clash_o,
  output logic                  range_o
);

  localparam int DEPTH_EVEN = bank_depth(NUM_COLS, 0, SLOTS, ROWS);
  localparam int DEPTH_ODD  = bank_depth(NUM_COLS, 1, SLOTS, ROWS);
  localparam int AW         = (DEPTH_EVEN > 1) ? $clog2(DEPTH_EVEN) : 1;

  logic                 rd_ok, rd_bad, wr_ok, wr_bad;
  acc_kind_t            rd_kind, wr_kind;
  logic [1:0]           rd_hit, wr_hit, rd_hi, wr_hi;
  logic [1:0][AW-1:0]   rd_addr, wr_addr;
  logic                 clash, rd_go;
  logic [1:0][WORD_W-1:0] bank_q;
  logic                 par_q, pair_q;

  pb_addr_gen #(
    .NUM_COLS(NUM_COLS), .SLOTS(SLOTS), .ROWS(ROWS),
    .COL_W(COL_W), .SLOT_W(SLOT_W), .ROW_W(ROW_W), .AW(AW)
  ) u_rd_gen (
    .en_i(rd_en_i), .pair_i(rd_pair_i), .col_i(rd_col_i),
    .slot_i(rd_slot_i), .row_i(rd_row_i),
    .ok_o(rd_ok), .bad_o(rd_bad), .kind_o(rd_kind),
    .hit_o(rd_hit), .hi_sel_o(rd_hi), .addr_o(rd_addr)
  );

  pb_addr_gen #(
    .NUM_COLS(NUM_COLS), .SLOTS(SLOTS), .ROWS(ROWS),
    .COL_W(COL_W), .SLOT_W(SLOT_W), .ROW_W(ROW_W), .AW(AW)
  ) u_wr_gen (
    .en_i(wr_en_i), .pair_i(wr_pair_i), .col_i(wr_col_i),
    .slot_i(wr_slot_i), .row_i(wr_row_i),
    .ok_o(wr_ok), .bad_o(wr_bad), .kind_o(wr_kind),
    .hit_o(wr_hit), .hi_sel_o(wr_hi), .addr_o(wr_addr)
  );

  // A bank serves one operation per cycle; on overlap the write keeps the port.
  assign clash = |(rd_hit & wr_hit);
  assign rd_go = rd_ok && !clash;

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      localparam int DEP = (b == 0) ? DEPTH_EVEN : DEPTH_ODD;
      logic              we, re;
      logic [AW-1:0]     addr;
      logic [WORD_W-1:0] wdata;

      assign we    = wr_hit[b];
      assign re    = rd_hit[b] && !clash;
      assign addr  = we ? wr_addr[b] : rd_addr[b];
      assign wdata = wr_hi[b] ? wr_data_i[2*WORD_W-1:WORD_W] : wr_data_i[WORD_W-1:0];

      pb_bank #(.DW(WORD_W), .DEPTH(DEP), .AW(AW)) u_bank (
        .clk(clk), .rst(rst), .we_i(we), .re_i(re),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(bank_q[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      clash_o    <= 1'b0;
      range_o    <= 1'b0;
      par_q      <= 1'b0;
      pair_q     <= 1'b0;
    end else begin
      rd_valid_o <= rd_go;
      clash_o    <= clash;
      range_o    <= rd_bad || wr_bad;
      if (rd_go) begin
        par_q  <= rd_col_i[0];
        pair_q <= (rd_kind == ACC_SPAN);
      end
    end
  end

  pb_lane_mux #(.W(WORD_W)) u_mux (
    .bank_i(bank_q), .par_i(par_q), .pair_i(pair_q), .data_o(rd_data_o)
  );

  // rd_hi is only meaningful for writes; kept to show the read lane order explicitly.
  logic unused_rd_hi;
  assign unused_rd_hi = ^rd_hi ^ ^wr_kind;

endmodule

// File: rtl/pb_checker.sv
`timescale 1ns/1ps
module pb_checker #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en_i,
  input logic                rd_pair_i,
  input logic                wr_en_i,
  input logic                rd_valid_o,
  input logic [2*WORD_W-1:0] rd_data_o,
  input logic                clash_o,
  input logic                range_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rd_valid_o && !clash_o && !range_o));

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_en_i));

  assert_single_hi_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !$past(rd_pair_i)) |-> (rd_data_o[2*WORD_W-1:WORD_W] == '0));

  assert_clash_needs_both_R6: assert property (@(posedge clk) disable iff (rst)
    clash_o |-> $past(rd_en_i && wr_en_i));

  assert_clash_drops_read_R6: assert property (@(posedge clk) disable iff (rst)
    clash_o |-> !rd_valid_o);

  assert_range_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
    range_o |-> $past(rd_en_i || wr_en_i));

  assert_range_no_clash_R7: assert property (@(posedge clk) disable iff (rst)
    !(range_o && clash_o));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> $stable(rd_data_o));

endmodule

bind pair_pixel_buffer pb_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .rd_pair_i(rd_pair_i),
  .wr_en_i(wr_en_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
  .clash_o(clash_o), .range_o(range_o)
);

// File: tb/sim_pair_pixel_buffer.sv
`timescale 1ns/1ps
module sim_pair_pixel_buffer;

  localparam int NUM_COLS = 11;
  localparam int SLOTS    = 4;
  localparam int ROWS     = 4;
  localparam int COL_W    = 4;
  localparam int SLOT_W   = 2;
  localparam int ROW_W    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en_i = 0, rd_pair_i = 0, wr_en_i = 0, wr_pair_i = 0;
  logic [COL_W-1:0]  rd_col_i = '0, wr_col_i = '0;
  logic [SLOT_W-1:0] rd_slot_i = '0, wr_slot_i = '0;
  logic [ROW_W-1:0]  rd_row_i = '0, wr_row_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        rd_valid_o, clash_o, range_o;
  logic [63:0] rd_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] model [NUM_COLS][SLOTS][ROWS];

  always #10 clk = ~clk;

  pair_pixel_buffer u0 (
    .clk(clk), .rst(rst),
    .rd_en_i(rd_en_i), .rd_pair_i(rd_pair_i), .rd_col_i(rd_col_i),
    .rd_slot_i(rd_slot_i), .rd_row_i(rd_row_i),
    .wr_en_i(wr_en_i), .wr_pair_i(wr_pair_i), .wr_col_i(wr_col_i),
    .wr_slot_i(wr_slot_i), .wr_row_i(wr_row_i), .wr_data_i(wr_data_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .clash_o(clash_o), .range_o(range_o)
  );

  function automatic logic [31:0] pat(int c, int s, int r, int salt);
    return {8'(c * 17 + salt), 8'(s * 29 + 3), 8'(r * 7 + salt), 8'(c ^ s ^ r ^ salt)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request cycle: drive at falling edge, return after the next falling edge.
  task automatic op(input bit re, input bit rp, input int rc, input int rs, input int rr,
                    input bit we, input bit wp, input int wc, input int ws, input int wr,
                    input logic [63:0] wd);
    @(negedge clk);
    rd_en_i = re; rd_pair_i = rp; rd_col_i = COL_W'(rc);
    rd_slot_i = SLOT_W'(rs); rd_row_i = ROW_W'(rr);
    wr_en_i = we; wr_pair_i = wp; wr_col_i = COL_W'(wc);
    wr_slot_i = SLOT_W'(ws); wr_row_i = ROW_W'(wr); wr_data_i = wd;
    @(negedge clk);
    rd_en_i = 0; wr_en_i = 0; rd_pair_i = 0; wr_pair_i = 0;
  endtask

  task automatic read_word(input int c, input int s, input int r, input string req);
    op(1, 0, c, s, r, 0, 0, 0, 0, 0, '0);
    chk(rd_valid_o == 1'b1, req, {63'd0, rd_valid_o}, 64'd1);
    chk(rd_data_o == {32'd0, model[c][s][r]}, req, rd_data_o, {32'd0, model[c][s][r]});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!rd_valid_o && !clash_o && !range_o, "R1 in reset", {61'd0, rd_valid_o, clash_o, range_o}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk(!rd_valid_o && !clash_o && !range_o, "R1 after release", {61'd0, rd_valid_o, clash_o, range_o}, 64'd0);
    chk(rd_data_o == 64'd0, "R1 data", rd_data_o, 64'd0);
  endtask

  task automatic t_fill_all();
    for (int c = 0; c < NUM_COLS; c++)
      for (int s = 0; s < SLOTS; s++)
        for (int r = 0; r < ROWS; r++) begin
          model[c][s][r] = pat(c, s, r, 1);
          op(0, 0, 0, 0, 0, 1, 0, c, s, r, {32'hDEAD_BEEF, pat(c, s, r, 1)});
        end
    for (int c = 0; c < NUM_COLS; c++)
      for (int s = 0; s < SLOTS; s++)
        for (int r = 0; r < ROWS; r++)
          read_word(c, s, r, "R2 R8 single readback");
  endtask

  task automatic t_pair_read();
    for (int c = 0; c < NUM_COLS - 1; c++) begin
      int s = c % SLOTS;
      int r = (c + 1) % ROWS;
      logic [63:0] e;
      e = {model[c + 1][s][r], model[c][s][r]};
      op(1, 1, c, s, r, 0, 0, 0, 0, 0, '0);
      chk(rd_valid_o == 1'b1, "R3 pair valid", {63'd0, rd_valid_o}, 64'd1);
      chk(rd_data_o == e, "R3 pair lanes", rd_data_o, e);
    end
  endtask

  task automatic t_pair_write();
    op(0, 0, 0, 0, 0, 1, 1, 3, 1, 2, 64'hA1A2A3A4_B1B2B3B4);
    model[3][1][2] = 32'hB1B2B3B4; model[4][1][2] = 32'hA1A2A3A4;
    read_word(3, 1, 2, "R4 pair write low to odd column");
    read_word(4, 1, 2, "R4 pair write high to next column");
    op(0, 0, 0, 0, 0, 1, 1, 6, 0, 3, 64'h11223344_55667788);
    model[6][0][3] = 32'h55667788; model[7][0][3] = 32'h11223344;
    read_word(6, 0, 3, "R4 pair write even column");
    read_word(7, 0, 3, "R4 pair write odd neighbour");
  endtask

  task automatic t_concurrent();
    op(1, 0, 2, 0, 0, 1, 0, 5, 0, 0, {32'd0, 32'hC0FFEE01});
    chk(rd_valid_o && !clash_o, "R5 even read with odd write", {62'd0, rd_valid_o, clash_o}, 64'd2);
    chk(rd_data_o == {32'd0, model[2][0][0]}, "R5 read data", rd_data_o, {32'd0, model[2][0][0]});
    model[5][0][0] = 32'hC0FFEE01;
    read_word(5, 0, 0, "R5 write landed");
    op(1, 0, 7, 2, 1, 1, 0, 8, 3, 3, {32'd0, 32'h0BADF00D});
    chk(rd_valid_o && !clash_o, "R5 odd read with even write", {62'd0, rd_valid_o, clash_o}, 64'd2);
    chk(rd_data_o == {32'd0, model[7][2][1]}, "R5 odd read data", rd_data_o, {32'd0, model[7][2][1]});
    model[8][3][3] = 32'h0BADF00D;
    read_word(8, 3, 3, "R5 even write landed");
  endtask

  task automatic t_clash();
    logic [63:0] prev;
    read_word(1, 1, 1, "R6 setup read");
    prev = rd_data_o;
    op(1, 0, 4, 0, 0, 1, 0, 6, 2, 2, {32'd0, 32'h5A5A0001});
    chk(clash_o && !rd_valid_o, "R6 same-bank clash", {62'd0, clash_o, rd_valid_o}, 64'd2);
    chk(rd_data_o == prev, "R9 data held on clash", rd_data_o, prev);
    @(negedge clk);
    chk(!clash_o && rd_data_o == prev, "R9 data held while idle", rd_data_o, prev);
    model[6][2][2] = 32'h5A5A0001;
    read_word(6, 2, 2, "R6 write wins clash");
    op(1, 1, 2, 0, 0, 1, 0, 9, 1, 0, {32'd0, 32'h5A5A0002});
    chk(clash_o && !rd_valid_o, "R6 pair read vs odd write", {62'd0, clash_o, rd_valid_o}, 64'd2);
    model[9][1][0] = 32'h5A5A0002;
    read_word(9, 1, 0, "R6 write wins pair clash");
  endtask

  task automatic t_range();
    op(0, 0, 0, 0, 0, 1, 1, NUM_COLS - 1, 0, 0, 64'hFFFF0000_FFFF0000);
    chk(range_o && !clash_o, "R7 pair write at last column", {62'd0, range_o, clash_o}, 64'd2);
    read_word(NUM_COLS - 1, 0, 0, "R7 last column unchanged");
    op(1, 1, NUM_COLS - 1, 1, 1, 0, 0, 0, 0, 0, '0);
    chk(range_o && !rd_valid_o, "R7 pair read at last column", {62'd0, range_o, rd_valid_o}, 64'd2);
    op(1, 0, 12, 0, 0, 0, 0, 0, 0, 0, '0);
    chk(range_o && !rd_valid_o, "R7 read past columns", {62'd0, range_o, rd_valid_o}, 64'd2);
    op(1, 0, 0, 3, 3, 1, 0, 14, 3, 3, {32'd0, 32'h77777777});
    chk(range_o && rd_valid_o && !clash_o, "R7 bad write, good read proceeds",
        {61'd0, range_o, rd_valid_o, clash_o}, 64'd6);
    chk(rd_data_o == {32'd0, model[0][3][3]}, "R7 good read data", rd_data_o, {32'd0, model[0][3][3]});
    read_word(0, 3, 3, "R7 even bank word untouched");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill_all();
    t_pair_read();
    t_pair_write();
    t_concurrent();
    t_clash();
    t_range();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule